// File: doc/BRIEF.md
# Tree-Search Reconfiguration Classifier Controller

This controller sequences a reconfigurable classifier fabric through a fixed three-level decision tree in order to label an input as one of the digits 0 to 9. At each step it asks an external context loader for one configuration page. It then waits for the loaded context to return a set of unsigned scores and uses them to pick the next page. The arithmetic of each context is outside the block. The controller only ranks scores, keeps the ranked alternatives of each level, and walks the tree depth first.

The root context scores three digit groups: group 0 = {1,2,3,8}, group 1 = {0,5,9}, group 2 = {4,6,7}. A group context scores its members, and the best-scoring member selects a leaf context. Each leaf scores a single hypothesis against a programmable threshold. If the leaf rejects, the search moves on to the next-ranked sibling. When every sibling has rejected, it moves on to the next-ranked group. When every leaf has rejected, the input is reported as not a digit. The number of pages requested for the classification is reported with the result, and a new classification is only accepted after the result has been taken.

Top module: `tree_search_ctrl`

## Requirements
- R1: After reset the block is idle: `start_ready` is 1, and `page_req_valid` and `res_valid` are 0.
- R2: A classification begins when `start_valid` and `start_ready` are both high on a clock edge. The first page requested is page 0 (root). A request holds `page_req_valid` and `page_req_id` steady until `page_ack`.
- R3: Page numbering is 0 for the root, 1+g for group g, and 4+d for the leaf of digit d. Score lane k is `score_bus[k*SCORE_W +: SCORE_W]`. The root uses lanes 0..2, one per group, and the group with the largest root score is requested next.
- R4: A group context uses one lane per member, with members listed in the order 1,2,3,8 / 0,5,9 / 4,6,7. Its best-scoring member's leaf is requested next. Lanes beyond the group size, and root lane 3, never take part in ranking.
- R5: Among equal scores, the lower lane ranks first.
- R6: A leaf uses lane 0. It accepts only when that score is strictly greater than the threshold. On acceptance the result carries the digit with `res_not_digit` = 0.
- R7: When a leaf rejects and its group has untried members, the next member in descending-score order is requested.
- R8: When every member of a group has rejected, the next group in the root's ranking is requested.
- R9: When all leaves of all groups have rejected, the result has `res_not_digit` = 1 and `res_digit` = 15.
- R10: `res_reconfigs` equals the number of pages requested during the classification, root included.
- R11: The result stays valid and unchanged until `res_ready`. `start_valid` has no effect until the result is accepted, and the block returns to idle afterwards.
- R12: The threshold resets to `THR_RESET` and takes `thr_wdata` on a cycle with `thr_we` high.
- R13: `score_valid` is ignored while a page request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request a new classification |
| start_ready | output | 1 | Idle, ready to start |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | SCORE_W | Threshold write value |
| page_req_valid | output | 1 | Page request outstanding |
| page_req_id | output | 4 | Requested page number |
| page_ack | input | 1 | Loader has installed the page |
| score_valid | input | 1 | Scores of the current context are present |
| score_bus | input | 4*SCORE_W | Four score lanes |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result accepted |
| res_digit | output | 4 | Digit found, 15 when none |
| res_not_digit | output | 1 | All hypotheses rejected |
| res_reconfigs | output | CNT_W | Pages requested for this result |

## Verification
The sweep uses each of the 1024 patterns of which leaves accept. The scores of the root and the groups are drawn from a two-bit range, so ties are frequent and test the lane-order tie break. A pattern with no accepting leaf checks the complete 14-page walk and the not-a-digit report. Patterns with a single accepting leaf deep in the ranking separate sibling backtracking from group backtracking. Leaf scores equal to the threshold test the strict comparison. Oversized scores on unused lanes show that lanes are masked, and stray `score_valid` pulses during requests show that they are ignored. The first half of the sweep runs on the reset threshold and the second half on a written threshold, which shows that the threshold register takes effect.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int MAX_BR     = 4;
  localparam int BR_IW      = $clog2(MAX_BR);
  localparam int ROOT_BR    = 3;
  localparam int PAGE_W     = 4;
  localparam int DIGIT_W    = 4;
  localparam int ROOT_PAGE  = 0;
  localparam int GROUP_BASE = 1;
  localparam int LEAF_BASE  = 4;
  localparam int NUM_PAGES  = 14;
  localparam logic [DIGIT_W-1:0] NO_DIGIT = 4'hF;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_SCORE, ST_DONE} st_e;
  typedef enum logic [1:0] {LVL_ROOT, LVL_GROUP, LVL_LEAF} lvl_e;

  function automatic logic [BR_IW:0] group_size(input logic [BR_IW-1:0] g);
    return (g == '0) ? (BR_IW+1)'(4) : (BR_IW+1)'(3);
  endfunction

  function automatic logic [DIGIT_W-1:0] group_member(input logic [1:0] g,
                                                      input logic [1:0] k);
    logic [DIGIT_W-1:0] d;
    case ({g, k})
      4'b0000: d = 4'd1;
      4'b0001: d = 4'd2;
      4'b0010: d = 4'd3;
      4'b0011: d = 4'd8;
      4'b0100: d = 4'd0;
      4'b0101: d = 4'd5;
      4'b0110: d = 4'd9;
      4'b1000: d = 4'd4;
      4'b1001: d = 4'd6;
      4'b1010: d = 4'd7;
      default: d = NO_DIGIT;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tsc_ranker.sv
module tsc_ranker #(
  parameter int NB = 4,
  parameter int SW = 8,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB*SW-1:0] scores,
  input  logic [IW:0]      n_valid,
  output logic [NB*IW-1:0] order
);
  logic [IW-1:0] rank [NB];

  for (genvar gi = 0; gi < NB; gi++) begin : g_rank
    always_comb begin
      logic [IW:0] acc;
      logic        vi;
      logic        vj;
      logic [SW-1:0] si;
      logic [SW-1:0] sj;
      acc = '0;
      vi  = ((IW+1)'(gi) < n_valid);
      si  = scores[gi*SW +: SW];
      for (int j = 0; j < NB; j++) begin
        vj = ((IW+1)'(j) < n_valid);
        sj = scores[j*SW +: SW];
        if (j != gi) begin
          if (vj && !vi)
            acc = acc + 1'b1;
          else if ((vj == vi) && ((sj > si) || ((sj == si) && (j < gi))))
            acc = acc + 1'b1;
        end
      end
      rank[gi] = acc[IW-1:0];
    end
  end

  always_comb begin
    order = '0;
    for (int p = 0; p < NB; p++) begin
      for (int i = 0; i < NB; i++) begin
        if (rank[i] == IW'(p))
          order[p*IW +: IW] = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tsc_page_map.sv
module tsc_page_map
  import tsc_pkg::*;
(
  input  logic [BR_IW-1:0]  grp_sel,
  input  logic [BR_IW-1:0]  leaf_grp,
  input  logic [BR_IW-1:0]  leaf_mem,
  output logic [PAGE_W-1:0] group_page,
  output logic [PAGE_W-1:0] leaf_page
);
  always_comb begin
    group_page = PAGE_W'(GROUP_BASE) + PAGE_W'(grp_sel);
    leaf_page  = PAGE_W'(LEAF_BASE) + PAGE_W'(group_member(leaf_grp, leaf_mem));
  end
endmodule

// File: rtl/tree_search_ctrl.sv
module tree_search_ctrl
  import tsc_pkg::*;
#(
  parameter int SCORE_W = 8,
  parameter int CNT_W   = 4,
  parameter logic [SCORE_W-1:0] THR_RESET = SCORE_W'(128)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_valid,
  output logic                      start_ready,
  input  logic                      thr_we,
  input  logic [SCORE_W-1:0]        thr_wdata,
  output logic                      page_req_valid,
  output logic [PAGE_W-1:0]         page_req_id,
  input  logic                      page_ack,
  input  logic                      score_valid,
  input  logic [MAX_BR*SCORE_W-1:0] score_bus,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [DIGIT_W-1:0]        res_digit,
  output logic                      res_not_digit,
  output logic [CNT_W-1:0]          res_reconfigs
);
  localparam int ORD_W = MAX_BR * BR_IW;

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  st_e                 st_q, st_d;
  lvl_e                lvl_q, lvl_d;
  logic [PAGE_W-1:0]   page_q, page_d;
  logic [ORD_W-1:0]    root_ord_q, root_ord_d;
  logic [ORD_W-1:0]    grp_ord_q, grp_ord_d;
  logic [BR_IW-1:0]    root_pos_q, root_pos_d;
  logic [BR_IW-1:0]    grp_pos_q, grp_pos_d;
  logic [BR_IW-1:0]    grp_q, grp_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DIGIT_W-1:0]  digit_q, digit_d;
  logic                nd_q, nd_d;
  logic [SCORE_W-1:0]  thr_q;

  // ranking of the current context's lanes
  logic [BR_IW:0]      rk_n;
  logic [ORD_W-1:0]    rk_order;
  logic [BR_IW-1:0]    rk_first;

  assign rk_n     = (lvl_q == LVL_ROOT) ? (BR_IW+1)'(ROOT_BR) : group_size(grp_q);
  assign rk_first = rk_order[BR_IW-1:0];

  tsc_ranker #(.NB(MAX_BR), .SW(SCORE_W)) u_rank (
    .scores  (score_bus),
    .n_valid (rk_n),
    .order   (rk_order)
  );

  // next-branch selection and page lookup
  logic [BR_IW-1:0]  root_nxt_pos, grp_nxt_pos;
  logic [BR_IW-1:0]  sel_grp, sel_mem;
  logic [PAGE_W-1:0] map_group_page, map_leaf_page;

  assign root_nxt_pos = root_pos_q + 1'b1;
  assign grp_nxt_pos  = grp_pos_q + 1'b1;
  assign sel_grp = (lvl_q == LVL_ROOT) ? rk_first
                                       : root_ord_q[root_nxt_pos*BR_IW +: BR_IW];
  assign sel_mem = (lvl_q == LVL_GROUP) ? rk_first
                                        : grp_ord_q[grp_nxt_pos*BR_IW +: BR_IW];

  tsc_page_map u_map (
    .grp_sel    (sel_grp),
    .leaf_grp   (grp_q),
    .leaf_mem   (sel_mem),
    .group_page (map_group_page),
    .leaf_page  (map_leaf_page)
  );

  logic [SCORE_W-1:0] leaf_score;
  logic               leaf_accept;
  logic               grp_more, root_more;

  assign leaf_score  = score_bus[SCORE_W-1:0];
  assign leaf_accept = leaf_score > thr_q;
  assign grp_more    = ({1'b0, grp_pos_q} + 1'b1) < group_size(grp_q);
  assign root_more   = ({1'b0, root_pos_q} + 1'b1) < (BR_IW+1)'(ROOT_BR);

  // next-state logic
  always_comb begin
    st_d       = st_q;
    lvl_d      = lvl_q;
    page_d     = page_q;
    root_ord_d = root_ord_q;
    grp_ord_d  = grp_ord_q;
    root_pos_d = root_pos_q;
    grp_pos_d  = grp_pos_q;
    grp_d      = grp_q;
    cnt_d      = cnt_q;
    digit_d    = digit_q;
    nd_d       = nd_q;
    case (st_q)
      ST_IDLE: begin
        if (start_valid) begin
          st_d    = ST_REQ;
          lvl_d   = LVL_ROOT;
          page_d  = PAGE_W'(ROOT_PAGE);
          cnt_d   = CNT_W'(1);
          digit_d = '0;
          nd_d    = 1'b0;
        end
      end
      ST_REQ: begin
        if (page_ack) st_d = ST_SCORE;
      end
      ST_SCORE: begin
        if (score_valid) begin
          case (lvl_q)
            LVL_ROOT: begin
              root_ord_d = rk_order;
              root_pos_d = '0;
              grp_d      = rk_first;
              lvl_d      = LVL_GROUP;
              page_d     = map_group_page;
              cnt_d      = cnt_q + 1'b1;
              st_d       = ST_REQ;
            end
            LVL_GROUP: begin
              grp_ord_d = rk_order;
              grp_pos_d = '0;
              lvl_d     = LVL_LEAF;
              page_d    = map_leaf_page;
              cnt_d     = cnt_q + 1'b1;
              st_d      = ST_REQ;
            end
            default: begin
              if (leaf_accept) begin
                digit_d = DIGIT_W'(page_q - PAGE_W'(LEAF_BASE));
                nd_d    = 1'b0;
                st_d    = ST_DONE;
              end else if (grp_more) begin
                grp_pos_d = grp_nxt_pos;
                page_d    = map_leaf_page;
                cnt_d     = cnt_q + 1'b1;
                st_d      = ST_REQ;
              end else if (root_more) begin
                root_pos_d = root_nxt_pos;
                grp_d      = sel_grp;
                lvl_d      = LVL_GROUP;
                page_d     = map_group_page;
                cnt_d      = cnt_q + 1'b1;
                st_d       = ST_REQ;
              end else begin
                digit_d = NO_DIGIT;
                nd_d    = 1'b1;
                st_d    = ST_DONE;
              end
            end
          endcase
        end
      end
      default: begin
        if (res_ready) st_d = ST_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= ST_IDLE;
      lvl_q      <= LVL_ROOT;
      page_q     <= '0;
      root_ord_q <= '0;
      grp_ord_q  <= '0;
      root_pos_q <= '0;
      grp_pos_q  <= '0;
      grp_q      <= '0;
      cnt_q      <= '0;
      digit_q    <= '0;
      nd_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      lvl_q      <= lvl_d;
      page_q     <= page_d;
      root_ord_q <= root_ord_d;
      grp_ord_q  <= grp_ord_d;
      root_pos_q <= root_pos_d;
      grp_pos_q  <= grp_pos_d;
      grp_q      <= grp_d;
      cnt_q      <= cnt_d;
      digit_q    <= digit_d;
      nd_q       <= nd_d;
    end
  end

  // threshold register with explicit enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  thr_q <= THR_RESET;
    else if (thr_we) thr_q <= thr_wdata;
  end

  assign start_ready    = (st_q == ST_IDLE);
  assign page_req_valid = (st_q == ST_REQ);
  assign page_req_id    = page_q;
  assign res_valid      = (st_q == ST_DONE);
  assign res_digit      = digit_q;
  assign res_not_digit  = nd_q;
  assign res_reconfigs  = cnt_q;
endmodule

// File: rtl/tsc_ctrl_chk.sv
module tsc_ctrl_chk
  import tsc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_valid,
  input logic               start_ready,
  input logic               page_req_valid,
  input logic [PAGE_W-1:0]  page_req_id,
  input logic               page_ack,
  input logic               res_valid,
  input logic               res_ready,
  input logic [DIGIT_W-1:0] res_digit,
  input logic               res_not_digit,
  input logic [CNT_W-1:0]   res_reconfigs
);
  assert_first_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> page_req_valid && (page_req_id == PAGE_W'(ROOT_PAGE)));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    page_req_valid && !page_ack |=> page_req_valid && $stable(page_req_id));

  assert_page_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_req_valid |-> page_req_id < PAGE_W'(NUM_PAGES));

  assert_accept_digit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_not_digit |-> (res_digit < 4'd10) && (res_reconfigs >= CNT_W'(3)));

  assert_exhaust_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_not_digit |-> (res_digit == NO_DIGIT) && (res_reconfigs == CNT_W'(NUM_PAGES)));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_digit) && $stable(res_not_digit)
                                && $stable(res_reconfigs));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> start_ready && !res_valid);
endmodule

bind tree_search_ctrl tsc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_valid    (start_valid),
  .start_ready    (start_ready),
  .page_req_valid (page_req_valid),
  .page_req_id    (page_req_id),
  .page_ack       (page_ack),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_digit      (res_digit),
  .res_not_digit  (res_not_digit),
  .res_reconfigs  (res_reconfigs)
);

// File: tb/tree_search_ctrl_tb_top.sv
`timescale 1ns/1ps
module tree_search_ctrl_tb_top;
  localparam int SW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic          thr_we = 1'b0;
  logic [SW-1:0] thr_wdata = '0;
  logic          page_req_valid;
  logic [3:0]    page_req_id;
  logic          page_ack = 1'b0;
  logic          score_valid = 1'b0;
  logic [4*SW-1:0] score_bus = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [3:0]    res_digit;
  logic          res_not_digit;
  logic [CW-1:0] res_reconfigs;

  always #2.5 clk = ~clk;

  tree_search_ctrl #(.SCORE_W(SW), .CNT_W(CW), .THR_RESET(8'd128)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .page_req_valid(page_req_valid),
    .page_req_id(page_req_id), .page_ack(page_ack), .score_valid(score_valid),
    .score_bus(score_bus), .res_valid(res_valid), .res_ready(res_ready),
    .res_digit(res_digit), .res_not_digit(res_not_digit), .res_reconfigs(res_reconfigs)
  );

  int checks = 0;
  int errors = 0;
  bit hung = 0;
  bit done_all = 0;

  int root_s [3];
  int grp_s  [3][4];
  int leaf_s [10];
  int thr_m;
  int exp_pages [16];
  int exp_n;
  int exp_digit;
  int exp_nd;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic int member(input int g, input int k);
    int m [3][4] = '{'{1, 2, 3, 8}, '{0, 5, 9, -1}, '{4, 6, 7, -1}};
    return m[g][k];
  endfunction

  function automatic int gsize(input int g);
    return (g == 0) ? 4 : 3;
  endfunction

  task automatic rank_ref(input int s[4], input int n, output int ord[4]);
    bit used [4] = '{0, 0, 0, 0};
    for (int p = 0; p < 4; p++) ord[p] = 0;
    for (int p = 0; p < n; p++) begin
      int best = -1;
      for (int i = 0; i < n; i++)
        if (!used[i] && (best < 0 || s[i] > s[best])) best = i;
      ord[p] = best;
      used[best] = 1;
    end
  endtask

  task automatic build_expected();
    int rs [4];
    int ro [4];
    int gs [4];
    int go [4];
    bit found = 0;
    rs = '{root_s[0], root_s[1], root_s[2], 0};
    rank_ref(rs, 3, ro);
    exp_n = 0;
    exp_pages[exp_n++] = 0;
    exp_digit = 15;
    exp_nd = 1;
    for (int rp = 0; rp < 3; rp++) begin
      if (!found) begin
        int g = ro[rp];
        exp_pages[exp_n++] = 1 + g;
        gs = '{grp_s[g][0], grp_s[g][1], grp_s[g][2], grp_s[g][3]};
        rank_ref(gs, gsize(g), go);
        for (int mp = 0; mp < gsize(g); mp++) begin
          if (!found) begin
            int d = member(g, go[mp]);
            exp_pages[exp_n++] = 4 + d;
            if (leaf_s[d] > thr_m) begin
              found = 1;
              exp_digit = d;
              exp_nd = 0;
            end
          end
        end
      end
    end
  endtask

  function automatic logic [4*SW-1:0] bus_for(input int page);
    logic [4*SW-1:0] b;
    b = '1;
    if (page == 0) begin
      for (int k = 0; k < 3; k++) b[k*SW +: SW] = SW'(root_s[k]);
    end else if (page <= 3) begin
      for (int k = 0; k < gsize(page - 1); k++) b[k*SW +: SW] = SW'(grp_s[page-1][k]);
    end else if (page <= 13) begin
      b[SW-1:0] = SW'(leaf_s[page-4]);
    end
    return b;
  endfunction

  task automatic run_one(input bit poke);
    int idx = 0;
    int guard = 0;
    logic [3:0] held_digit;
    logic [CW-1:0] held_cnt;
    build_expected();
    while (!start_ready && guard < 20) begin @(negedge clk); guard++; end
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    guard = 0;
    while (!res_valid && !hung) begin
      if (page_req_valid) begin
        int id = int'(page_req_id);
        // R2 first page is root; R3/R4/R5/R7/R8 page order
        chk(idx < exp_n && id == exp_pages[idx],
            "R2/R3/R4/R5/R7/R8 page order", id, (idx < exp_n) ? exp_pages[idx] : -1);
        if (poke) begin
          score_valid = 1'b1;
          score_bus = '1;
          @(negedge clk);
          score_valid = 1'b0;
          chk(page_req_valid && page_req_id == 4'(id), "R13 score ignored while requesting",
              int'(page_req_id), id);
        end
        page_ack = 1'b1;
        @(negedge clk);
        page_ack = 1'b0;
        score_valid = 1'b1;
        score_bus = bus_for(id);
        @(negedge clk);
        score_valid = 1'b0;
        idx++;
        guard = 0;
      end else begin
        @(negedge clk);
        guard++;
        if (guard > 50) begin
          hung = 1;
          chk(0, "watchdog stall", 0, 1);
        end
      end
    end
    if (hung) return;
    chk(int'(res_not_digit) == exp_nd, "R6/R9/R12 not-digit flag", int'(res_not_digit), exp_nd);
    chk(int'(res_digit) == exp_digit, "R6/R9/R12 digit", int'(res_digit), exp_digit);
    chk(int'(res_reconfigs) == exp_n, "R10 reconfiguration count", int'(res_reconfigs), exp_n);
    chk(idx == exp_n, "R10 pages requested", idx, exp_n);
    held_digit = res_digit;
    held_cnt = res_reconfigs;
    start_valid = 1'b1;
    repeat (2) @(negedge clk);
    start_valid = 1'b0;
    chk(res_valid && !start_ready && !page_req_valid && res_digit == held_digit
        && res_reconfigs == held_cnt, "R11 result held, start ignored",
        int'(res_valid), 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(start_ready && !res_valid, "R11 back to idle after accept", int'(start_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(start_ready && !page_req_valid && !res_valid, "R1 reset state",
        int'({start_ready, page_req_valid, res_valid}), 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(start_ready && !page_req_valid && !res_valid, "R1 idle after reset release",
        int'({start_ready, page_req_valid, res_valid}), 4);
    thr_m = 128;

    // directed: all scores tied, every leaf equal to threshold (rejects)
    for (int k = 0; k < 3; k++) root_s[k] = 7;
    for (int g = 0; g < 3; g++) for (int k = 0; k < 4; k++) grp_s[g][k] = 9;
    for (int d = 0; d < 10; d++) leaf_s[d] = thr_m;
    run_one(1'b1);

    // sweep over every accept pattern of the ten leaves
    for (int t = 0; t < 1024 && !hung; t++) begin
      if (t == 512) begin
        thr_wdata = 8'd100;
        thr_we = 1'b1;
        @(negedge clk);
        thr_we = 1'b0;
        thr_m = 100; // R12 written threshold
      end
      for (int k = 0; k < 3; k++) root_s[k] = ((t >> (2 * k)) ^ (t >> 5)) & 3;
      for (int g = 0; g < 3; g++)
        for (int k = 0; k < 4; k++) grp_s[g][k] = ((t * (k + 1) + g * 3) >> 2) & 3;
      for (int d = 0; d < 10; d++)
        leaf_s[d] = ((t >> d) & 1) ? thr_m + 1 + ((t + d) % 3) : thr_m - ((t + d) % 3);
      run_one(t % 8 == 0);
    end
    done_all = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule